// File: doc/BRIEF.md
# Machine Lifecycle State Controller

This block keeps the one authoritative lifecycle state of an industrial machine. It takes operator commands (start, pause, resume, stop, reset acknowledge), an init-done flag, a vector of permissive bits, stop-complete and recovery-complete flags, and a fault-active flag with a safety-class qualifier. A single state register moves through the normal lifecycle: initialise, idle, ready, run, pause, stopping and stopped. Faults form a side branch through a fault state and a recovery state.

A fault seen in any cycle moves the machine to the fault state on the next clock, whatever else is asserted. Leaving the fault state is guarded. The fault must have cleared first. If a safety-class fault was latched, an operator reset acknowledge is also needed. A plain fault clears by itself. Output decoding is kept apart from the transition logic. The encoded state, a one-hot copy of it and a run-enable are all registered from the same next-state value, so they always agree with each other in every cycle.

Top module: `lc_ctrl`

## Requirements
- R1: When rst_ni is low, state_o is 0 (INIT), state_oh_o is 9'b000000001 and run_en_o is 0.
- R2: state_oh_o always has exactly one bit set, and that bit sits at index state_o. The codes are INIT=0, IDLE=1, READY=2, RUN=3, PAUSE=4, STOPPING=5, STOPPED=6, FAULT=7, RECOVERY=8.
- R3: If fault_i is high at a clock edge, state_o is 7 (FAULT) after that edge, whatever the state and the other inputs are.
- R4: READY moves to RUN only when every bit of perm_i is 1, fault_i is 0 and start_i is 1, all in the same cycle.
- R5: INIT moves to IDLE on init_done_i. IDLE moves to READY when every perm_i bit is 1. READY returns to IDLE when any perm_i bit is 0, and this takes priority over start_i.
- R6: In RUN, stop_i moves to STOPPING, ahead of pause_i, and pause_i alone moves to PAUSE. In PAUSE, stop_i moves to STOPPING, and resume_i together with all perm_i bits at 1 moves back to RUN.
- R7: STOPPING moves to STOPPED on stop_done_i. STOPPED moves to IDLE on start_i.
- R8: Once a fault with fault_safe_i high has been latched, FAULT is left only in a cycle where fault_i is 0 and reset_ack_i is 1. It then goes to RECOVERY.
- R9: Without a latched safety-class fault, FAULT moves to RECOVERY in any cycle where fault_i is 0. The safety latch is set by fault_i and fault_safe_i both high on entry to FAULT or while in FAULT, and it is cleared when FAULT is left.
- R10: RECOVERY moves to IDLE on recov_done_i.
- R11: run_en_o is 1 exactly when state_o is 3 (RUN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Initialisation finished |
| start_i | input | 1 | Operator start command |
| pause_i | input | 1 | Operator pause command |
| resume_i | input | 1 | Operator resume command |
| stop_i | input | 1 | Operator stop command |
| reset_ack_i | input | 1 | Operator reset acknowledge |
| perm_i | input | NUM_PERMS | Permissive bits, all must be 1 |
| stop_done_i | input | 1 | Stop sequence complete |
| recov_done_i | input | 1 | Recovery sequence complete |
| fault_i | input | 1 | Fault active |
| fault_safe_i | input | 1 | Active fault is safety class |
| state_o | output | 4 | Encoded current state |
| state_oh_o | output | 9 | One-hot current state |
| run_en_o | output | 1 | Run enable, high only in RUN |

## Verification
The bench builds the block with NUM_PERMS set to 3. With a narrow vector, random permissive patterns often have exactly one bit low, which exercises the READY fallback and the refused run entry. The stimulus is biased towards all permissives being true, so that RUN, PAUSE and the stop path are reached often. Faults are kept rare and their safety class is random, so both the manual exit from FAULT and the automatic exit are seen many times.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned STATE_W    = 4;
  localparam int unsigned NUM_STATES = 9;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT     = 4'd0,
    ST_IDLE     = 4'd1,
    ST_READY    = 4'd2,
    ST_RUN      = 4'd3,
    ST_PAUSE    = 4'd4,
    ST_STOPPING = 4'd5,
    ST_STOPPED  = 4'd6,
    ST_FAULT    = 4'd7,
    ST_RECOVERY = 4'd8
  } lc_state_e;
endpackage

// File: rtl/lc_next.sv
module lc_next
  import lc_pkg::*;
#(
  parameter int unsigned NUM_PERMS = 4
) (
  input  lc_state_e              state_i,
  input  logic                   safe_i,
  input  logic                   init_done_i,
  input  logic                   start_i,
  input  logic                   pause_i,
  input  logic                   resume_i,
  input  logic                   stop_i,
  input  logic                   reset_ack_i,
  input  logic [NUM_PERMS-1:0]   perm_i,
  input  logic                   stop_done_i,
  input  logic                   recov_done_i,
  input  logic                   fault_i,
  output lc_state_e              state_d_o
);
  logic perm_ok;
  assign perm_ok = &perm_i;

  always_comb begin
    state_d_o = state_i;
    if (fault_i) begin
      state_d_o = ST_FAULT;  // pre-emption, overrides everything
    end else begin
      case (state_i)
        ST_INIT:     if (init_done_i) state_d_o = ST_IDLE;
        ST_IDLE:     if (perm_ok) state_d_o = ST_READY;
        ST_READY: begin
          if (!perm_ok)     state_d_o = ST_IDLE;
          else if (start_i) state_d_o = ST_RUN;
        end
        ST_RUN: begin
          if (stop_i)       state_d_o = ST_STOPPING;
          else if (pause_i) state_d_o = ST_PAUSE;
        end
        ST_PAUSE: begin
          if (stop_i)                   state_d_o = ST_STOPPING;
          else if (resume_i && perm_ok) state_d_o = ST_RUN;
        end
        ST_STOPPING: if (stop_done_i) state_d_o = ST_STOPPED;
        ST_STOPPED:  if (start_i) state_d_o = ST_IDLE;
        ST_FAULT:    if (!safe_i || reset_ack_i) state_d_o = ST_RECOVERY;
        ST_RECOVERY: if (recov_done_i) state_d_o = ST_IDLE;
        default:     state_d_o = ST_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/lc_safe_latch.sv
module lc_safe_latch
  import lc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lc_state_e state_d_i,
  input  logic      fault_i,
  input  logic      fault_safe_i,
  output logic      safe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      safe_o <= 1'b0;
    end else if (state_d_i == ST_FAULT) begin
      safe_o <= safe_o | (fault_i & fault_safe_i);
    end else begin
      safe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lc_decode.sv
module lc_decode
  import lc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  lc_state_e             state_d_i,
  output logic [NUM_STATES-1:0] state_oh_o,
  output logic                  run_en_o
);
  for (genvar g = 0; g < NUM_STATES; g++) begin : g_oh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_oh_o[g] <= (g == 0);
      else         state_oh_o[g] <= (state_d_i == lc_state_e'(g));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_en_o <= 1'b0;
    else         run_en_o <= (state_d_i == ST_RUN);
  end
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int unsigned NUM_PERMS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  init_done_i,
  input  logic                  start_i,
  input  logic                  pause_i,
  input  logic                  resume_i,
  input  logic                  stop_i,
  input  logic                  reset_ack_i,
  input  logic [NUM_PERMS-1:0]  perm_i,
  input  logic                  stop_done_i,
  input  logic                  recov_done_i,
  input  logic                  fault_i,
  input  logic                  fault_safe_i,
  output logic [STATE_W-1:0]    state_o,
  output logic [NUM_STATES-1:0] state_oh_o,
  output logic                  run_en_o
);
  lc_state_e state_q, state_d;
  logic      safe_q;

  lc_next #(.NUM_PERMS(NUM_PERMS)) u_next (
    .state_i      (state_q),
    .safe_i       (safe_q),
    .init_done_i  (init_done_i),
    .start_i      (start_i),
    .pause_i      (pause_i),
    .resume_i     (resume_i),
    .stop_i       (stop_i),
    .reset_ack_i  (reset_ack_i),
    .perm_i       (perm_i),
    .stop_done_i  (stop_done_i),
    .recov_done_i (recov_done_i),
    .fault_i      (fault_i),
    .state_d_o    (state_d)
  );

  // sole owner of the lifecycle state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT;
    else         state_q <= state_d;
  end

  lc_safe_latch u_safe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_d_i    (state_d),
    .fault_i      (fault_i),
    .fault_safe_i (fault_safe_i),
    .safe_o       (safe_q)
  );

  lc_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .state_oh_o (state_oh_o),
    .run_en_o   (run_en_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/lc_ctrl_chk.sv
module lc_ctrl_chk
  import lc_pkg::*;
#(
  parameter int unsigned NUM_PERMS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  reset_ack_i,
  input logic [NUM_PERMS-1:0]  perm_i,
  input logic                  fault_i,
  input logic                  safe_i,
  input logic [STATE_W-1:0]    state_o,
  input logic [NUM_STATES-1:0] state_oh_o,
  input logic                  run_en_o
);
  AST_FAULT_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> state_o == 4'd7); // R3

  AST_RUN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd2 && !(start_i && !fault_i && (&perm_i))) |=> state_o != 4'd3); // R4

  AST_SAFE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd7 && safe_i && !reset_ack_i) |=> state_o == 4'd7); // R8

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_oh_o) == 1 && state_oh_o[state_o] == 1'b1); // R2

  AST_RUN_EN_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o == (state_o == 4'd3)); // R11
endmodule

bind lc_ctrl lc_ctrl_chk #(.NUM_PERMS(NUM_PERMS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .reset_ack_i (reset_ack_i),
  .perm_i      (perm_i),
  .fault_i     (fault_i),
  .safe_i      (safe_q),
  .state_o     (state_o),
  .state_oh_o  (state_oh_o),
  .run_en_o    (run_en_o)
);

// File: tb/lc_ctrl_bench.sv
module lc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic init_done, start, pause, resume, stop, reset_ack, stop_done, recov_done;
  logic fault, fault_safe;
  logic [NP-1:0] perm;
  logic [3:0] state;
  logic [8:0] state_oh;
  logic run_en;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_state = 4'd0;
  logic m_safe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lc_ctrl #(.NUM_PERMS(NP)) u_lc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .init_done_i(init_done), .start_i(start),
    .pause_i(pause), .resume_i(resume), .stop_i(stop), .reset_ack_i(reset_ack),
    .perm_i(perm), .stop_done_i(stop_done), .recov_done_i(recov_done),
    .fault_i(fault), .fault_safe_i(fault_safe), .state_o(state),
    .state_oh_o(state_oh), .run_en_o(run_en)
  );

  function automatic logic [3:0] model_next(logic [3:0] s, logic sf);
    logic ok;
    ok = &perm;
    if (fault) return 4'd7;
    case (s)
      4'd0: return init_done ? 4'd1 : s;
      4'd1: return ok ? 4'd2 : s;
      4'd2: return !ok ? 4'd1 : (start ? 4'd3 : s);
      4'd3: return stop ? 4'd5 : (pause ? 4'd4 : s);
      4'd4: return stop ? 4'd5 : ((resume && ok) ? 4'd3 : s);
      4'd5: return stop_done ? 4'd6 : s;
      4'd6: return start ? 4'd1 : s;
      4'd7: return (!sf || reset_ack) ? 4'd8 : s;
      4'd8: return recov_done ? 4'd1 : s;
      default: return 4'd7;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] s, logic sf);
    if (fault) return "R3";
    case (s)
      4'd0, 4'd1: return "R5";
      4'd2: return "R4";
      4'd3, 4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      4'd7: return sf ? "R8" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    init_done = 0; start = 0; pause = 0; resume = 0; stop = 0; reset_ack = 0;
    stop_done = 0; recov_done = 0; fault = 0; fault_safe = 0; perm = '1;
  endtask

  // one clock: predict, clock, compare away from the edge
  task automatic step();
    logic [3:0] nx;
    string t;
    nx = model_next(m_state, m_safe);
    t = tag_of(m_state, m_safe);
    @(posedge clk);
    #1;
    m_safe = (nx == 4'd7) ? (m_safe | (fault & fault_safe)) : 1'b0;
    m_state = nx;
    check(t, state, m_state);
    check("R2", state_oh, 9'd1 << m_state);
    check("R11", run_en, m_state == 4'd3);
  endtask

  task automatic randomize_inputs();
    init_done  = ($urandom % 3) == 0;
    start      = ($urandom % 4) == 0;
    pause      = ($urandom % 4) == 0;
    resume     = ($urandom % 4) == 0;
    stop       = ($urandom % 6) == 0;
    reset_ack  = ($urandom % 5) == 0;
    stop_done  = ($urandom % 3) == 0;
    recov_done = ($urandom % 3) == 0;
    fault      = ($urandom % 20) == 0;
    fault_safe = $urandom % 2;
    perm       = (($urandom % 5) != 0) ? '1 : NP'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle_inputs();
    #(CLK_PERIOD * 2 + 1);
    check("R1", state, 4'd0);
    check("R1", state_oh, 9'd1);
    check("R1", run_en, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5: INIT -> IDLE -> READY; one permissive low drops back, start refused (R4)
    init_done = 1; step(); init_done = 0;
    step();
    perm = 3'b101; start = 1; step();
    check("R4", state, 4'd1);
    perm = '1; start = 0; step();
    start = 1; fault = 1; step();      // fault beats start, R3
    check("R3", state, 4'd7);
    // R8: safety fault holds until ack
    fault = 1; fault_safe = 1; start = 0; step();
    fault = 0; fault_safe = 0; step(); step();
    check("R8", state, 4'd7);
    reset_ack = 1; step(); reset_ack = 0;
    check("R8", state, 4'd8);
    recov_done = 1; step(); recov_done = 0;
    check("R10", state, 4'd1);
    // R9: plain fault exits by itself
    fault = 1; step(); fault = 0; step();
    check("R9", state, 4'd8);
    recov_done = 1; step(); recov_done = 0;
    step(); start = 1; step(); start = 0;
    check("R4", state, 4'd3);
    stop = 1; pause = 1; step(); stop = 0; pause = 0;
    check("R6", state, 4'd5);

    // asynchronous reset mid-flight, R1
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1", state, 4'd0);
    check("R1", run_en, 1'b0);
    m_state = 4'd0; m_safe = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 4000; i++) begin
      randomize_inputs();
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule